// File: doc/BRIEF.md
# Update-Form Load/Store Address Unit

This block sits in a load/store pipeline. For memory operations that update their base register, it forms the memory address and the new base-register value. It also shapes the data on both sides of the memory port. Each accepted operation carries five choices:

- an access size of 1, 2, 4 or 8 bytes;
- a signedness flag for loads;
- a load/store select;
- an address timing choice:
  - **pre-update**: memory sees base plus offset;
  - **post-update**: memory sees the untouched base, and the offset is applied only to the value written back;
- an offset source: a sign-extended immediate, a doubleword-style immediate whose two low bits are forced to zero, or a second (index) register.

An accepted operation produces a single-cycle memory request on the next clock. When the memory response arrives, the block presents both register writebacks in that same cycle, each with its own strobe:

- the loaded result, zero- or sign-extended to XLEN bits;
- the updated base value.

Stores return only the base writeback. Only one operation is in flight at a time. Operations offered while one is in flight are dropped.

Top module: `ldst_upd_agu`

## Requirements
- R1: With `op_post`=1, `mem_addr` equals the base register value of the accepted operation, with no offset added.
- R2: With `op_post`=0, `mem_addr` equals base plus offset (modulo 2^XLEN), and `base_wb_data` carries that same address.
- R3: With `op_post`=1, `base_wb_data` equals the old base plus the offset (modulo 2^XLEN).
- R4: The offset is selected as follows:
  - `op_indexed`=1: the offset is `index_val`;
  - otherwise, `op_ds_form`=1: the offset is the immediate with bits 1:0 cleared, then sign-extended from bit IMM_W-1;
  - otherwise: the offset is the immediate sign-extended from bit IMM_W-1.
- R5: Size codes are 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes. A load without sign extension returns the low bytes of `mem_rdata` with all higher bits zero. `op_signed` has no effect on size codes 0 and 3.
- R6: A load with `op_signed`=1 and size code 1 or 2 returns the low 2 or 4 bytes sign-extended to XLEN bits.
- R7: The request carries `mem_size` equal to the size code and `mem_store` equal to `op_store`. For stores, `mem_wdata` holds the low bytes of `src_val` for the access size, with higher bits zero.
- R8: `mem_req_valid` pulses for exactly one cycle, in the cycle after an operation is accepted. `busy` is 1 from that cycle until the cycle after the response.
- R9: In a cycle with `mem_rsp_valid`=1 while busy, `base_wb_valid` is 1 for every operation and `res_valid` is 1 only for loads. Both strobes are 0 in every other cycle.
- R10: `op_valid` while `busy`=1 is ignored. No new request is issued, and the writeback of the operation in flight is unchanged.
- R11: After reset, `busy`, `mem_req_valid`, `res_valid` and `base_wb_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation offered; accepted when not busy |
| op_size | input | 2 | Access size code (0..3 = 1,2,4,8 bytes) |
| op_signed | input | 1 | Sign-extend halfword/word loads |
| op_store | input | 1 | 1 = store, 0 = load |
| op_post | input | 1 | 1 = post-update, 0 = pre-update |
| op_indexed | input | 1 | Offset comes from the index register |
| op_ds_form | input | 1 | Immediate with low two bits forced to zero |
| base_val | input | XLEN | Base register value |
| index_val | input | XLEN | Index register value |
| imm | input | IMM_W | Immediate displacement |
| src_val | input | XLEN | Store source register value |
| mem_req_valid | output | 1 | Memory request strobe |
| mem_addr | output | XLEN | Memory address |
| mem_size | output | 2 | Access size code |
| mem_store | output | 1 | Request is a store |
| mem_wdata | output | XLEN | Store data, right-justified |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rdata | input | XLEN | Load data, right-justified |
| busy | output | 1 | An operation is in flight |
| res_valid | output | 1 | Destination register write strobe |
| res_data | output | XLEN | Formatted load result |
| base_wb_valid | output | 1 | Base register write strobe |
| base_wb_data | output | XLEN | Updated base register value |

## Verification
The bench builds the block with its defaults, XLEN=64 and IMM_W=16. At that width the full 64-bit carry chain of the base update is exercised, and every size code, including the full-width doubleword, can be swept. It sweeps every combination of the six operation controls against four data patterns. The patterns combine positive and negative immediates with read data whose byte, halfword and word sign bits are all set or all clear. This separates old-base from new-base addressing and zero extension from sign extension. A separate sequence offers conflicting operations while one is in flight.

// File: rtl/ldst_upd_pkg.sv
package ldst_upd_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } acc_size_e;

    localparam int NUM_SIZES = 4;

    // bytes covered by a size code
    function automatic int size_bytes(input logic [1:0] sz);
        return 1 << sz;
    endfunction

endpackage

// File: rtl/ldst_upd_addr.sv
module ldst_upd_addr #(
    parameter int XLEN  = 64,
    parameter int IMM_W = 16
) (
    input  logic [XLEN-1:0]  base_i,
    input  logic [XLEN-1:0]  index_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             indexed_i,
    input  logic             ds_form_i,
    input  logic             post_i,
    output logic [XLEN-1:0]  ea_o,
    output logic [XLEN-1:0]  wb_o
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [IMM_W-1:0] imm_eff;
    logic [XLEN-1:0]  imm_ext;
    logic [XLEN-1:0]  offset;
    logic [XLEN-1:0]  updated;

    always_comb begin
        imm_eff = ds_form_i ? {imm_i[IMM_W-1:2], 2'b00} : imm_i;
        imm_ext = {{EXT_W{imm_eff[IMM_W-1]}}, imm_eff};
        offset  = indexed_i ? index_i : imm_ext;
        updated = base_i + offset;
        ea_o    = post_i ? base_i : updated;
        wb_o    = updated;
    end

    // R1
    always_comb begin
        post_addr_chk: assert (!post_i || ea_o == base_i || $isunknown(base_i));
    end
endmodule

// File: rtl/ldst_upd_store_fmt.sv
module ldst_upd_store_fmt
    import ldst_upd_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] src_i,
    input  logic [1:0]      size_i,
    output logic [XLEN-1:0] data_o
);
    logic [XLEN-1:0] cand [NUM_SIZES];

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_sz
        localparam int NB = 8 << g;
        if (NB >= XLEN) begin : g_full
            assign cand[g] = src_i;
        end else begin : g_part
            assign cand[g] = {{(XLEN-NB){1'b0}}, src_i[NB-1:0]};
        end
    end

    assign data_o = cand[size_i];
endmodule

// File: rtl/ldst_upd_load_fmt.sv
module ldst_upd_load_fmt
    import ldst_upd_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] rdata_i,
    input  logic [1:0]      size_i,
    input  logic            signed_i,
    output logic [XLEN-1:0] data_o
);
    logic [XLEN-1:0] zcand [NUM_SIZES];
    logic [XLEN-1:0] scand [NUM_SIZES];

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_sz
        localparam int NB = 8 << g;
        if (NB >= XLEN) begin : g_full
            assign zcand[g] = rdata_i;
            assign scand[g] = rdata_i;
        end else begin : g_part
            assign zcand[g] = {{(XLEN-NB){1'b0}}, rdata_i[NB-1:0]};
            assign scand[g] = {{(XLEN-NB){rdata_i[NB-1]}}, rdata_i[NB-1:0]};
        end
    end

    logic use_sign;
    always_comb begin
        // algebraic extension only for halfword and word
        use_sign = signed_i && (size_i == SZ_HALF || size_i == SZ_WORD);
        data_o   = use_sign ? scand[size_i] : zcand[size_i];
    end
endmodule

// File: rtl/ldst_upd_agu.sv
module ldst_upd_agu
    import ldst_upd_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_size,
    input  logic             op_signed,
    input  logic             op_store,
    input  logic             op_post,
    input  logic             op_indexed,
    input  logic             op_ds_form,
    input  logic [XLEN-1:0]  base_val,
    input  logic [XLEN-1:0]  index_val,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  src_val,
    output logic             mem_req_valid,
    output logic [XLEN-1:0]  mem_addr,
    output logic [1:0]       mem_size,
    output logic             mem_store,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic             mem_rsp_valid,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             busy,
    output logic             res_valid,
    output logic [XLEN-1:0]  res_data,
    output logic             base_wb_valid,
    output logic [XLEN-1:0]  base_wb_data
);
    localparam int EXT_W = XLEN - IMM_W;

    typedef struct packed {
        logic            pend;
        logic            req_v;
        logic [XLEN-1:0] addr;
        logic [1:0]      size;
        logic            store;
        logic            sgn;
        logic [XLEN-1:0] wdata;
        logic [XLEN-1:0] wb;
    } agu_state_t;

    agu_state_t st_d, st_q;

    logic [XLEN-1:0] ea_w, wb_w, wdata_w, ldres_w;
    logic            accept, rsp_hit;

    ldst_upd_addr #(.XLEN(XLEN), .IMM_W(IMM_W)) u_addr (
        .base_i    (base_val),
        .index_i   (index_val),
        .imm_i     (imm),
        .indexed_i (op_indexed),
        .ds_form_i (op_ds_form),
        .post_i    (op_post),
        .ea_o      (ea_w),
        .wb_o      (wb_w)
    );

    ldst_upd_store_fmt #(.XLEN(XLEN)) u_sfmt (
        .src_i  (src_val),
        .size_i (op_size),
        .data_o (wdata_w)
    );

    ldst_upd_load_fmt #(.XLEN(XLEN)) u_lfmt (
        .rdata_i  (mem_rdata),
        .size_i   (st_q.size),
        .signed_i (st_q.sgn),
        .data_o   (ldres_w)
    );

    always_comb begin
        accept   = op_valid && !st_q.pend;
        rsp_hit  = st_q.pend && mem_rsp_valid;
        st_d       = st_q;
        st_d.req_v = 1'b0;
        if (rsp_hit) begin
            st_d.pend = 1'b0;
        end
        if (accept) begin
            st_d.pend  = 1'b1;
            st_d.req_v = 1'b1;
            st_d.addr  = ea_w;
            st_d.size  = op_size;
            st_d.store = op_store;
            st_d.sgn   = op_signed;
            st_d.wdata = op_store ? wdata_w : '0;
            st_d.wb    = wb_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_req_valid = st_q.req_v;
    assign mem_addr      = st_q.addr;
    assign mem_size      = st_q.size;
    assign mem_store     = st_q.store;
    assign mem_wdata     = st_q.wdata;
    assign busy          = st_q.pend;
    assign res_valid     = rsp_hit && !st_q.store;
    assign res_data      = ldres_w;
    assign base_wb_valid = rsp_hit;
    assign base_wb_data  = st_q.wb;

    // R8
    req_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy) |=> (mem_req_valid && busy));

    // R8
    req_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R1
    post_uses_old_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && op_post) |=> (mem_addr == $past(base_val)));

    // R2
    pre_imm_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && !op_post && !op_indexed && !op_ds_form)
        |=> (mem_addr == $past(base_val + {{EXT_W{imm[IMM_W-1]}}, imm})));

    // R9
    wb_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_wb_valid |-> (mem_rsp_valid && busy));

    // R9
    res_with_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (base_wb_valid && !mem_store));

    // R10
    busy_holds_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_rsp_valid) |=> $stable(base_wb_data));
endmodule

// File: tb/ldst_upd_agu_test.sv
module ldst_upd_agu_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_size = '0;
    logic        op_signed = 1'b0, op_store = 1'b0, op_post = 1'b0;
    logic        op_indexed = 1'b0, op_ds_form = 1'b0;
    logic [63:0] base_val = '0, index_val = '0, src_val = '0, mem_rdata = '0;
    logic [15:0] imm = '0;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_req_valid, mem_store, busy, res_valid, base_wb_valid;
    logic [63:0] mem_addr, mem_wdata, res_data, base_wb_data;
    logic [1:0]  mem_size;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ldst_upd_agu uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_size(op_size),
        .op_signed(op_signed), .op_store(op_store), .op_post(op_post),
        .op_indexed(op_indexed), .op_ds_form(op_ds_form), .base_val(base_val),
        .index_val(index_val), .imm(imm), .src_val(src_val),
        .mem_req_valid(mem_req_valid), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_store(mem_store), .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rdata(mem_rdata), .busy(busy), .res_valid(res_valid),
        .res_data(res_data), .base_wb_valid(base_wb_valid), .base_wb_data(base_wb_data)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] offset_of(input logic ix, input logic ds,
                                              input logic [15:0] im, input logic [63:0] xv);
        logic [63:0] v;
        if (ix) return xv;
        v = 64'($signed(im));
        if (ds) v = v - 64'(im[1:0]);
        return v;
    endfunction

    function automatic logic [63:0] low_mask(input logic [1:0] sz);
        if (sz == 2'd3) return '1;
        return (64'd1 << (8 * (1 << sz))) - 64'd1;
    endfunction

    function automatic logic [63:0] load_exp(input logic [1:0] sz, input logic sg,
                                             input logic [63:0] rd);
        logic [63:0] m = low_mask(sz);
        logic [63:0] v = rd & m;
        int top = 8 * (1 << sz) - 1;
        if (sg && (sz == 2'd1 || sz == 2'd2) && rd[top]) v = v | ~m;
        return v;
    endfunction

    // one operation: accept, request, response, idle
    task automatic run_op(input logic [1:0] sz, input logic sg, input logic st,
                          input logic po, input logic ix, input logic ds, input int p);
        logic [63:0] off, newb, b, rd, s, x;
        logic [15:0] im;
        b  = 64'h1000_0000_0000_0100 * 64'(p + 1) + 64'hFFF0;
        x  = (p[0]) ? 64'hFFFF_FFFF_FFFF_FF00 : 64'h0000_0001_0000_0040;
        im = (p[0]) ? 16'h8006 : 16'h0127;
        rd = (p[1]) ? 64'hF1E2_D3C4_B5A6_9788 : 64'h7123_4567_0123_4567;
        s  = ~rd;
        off  = offset_of(ix, ds, im, x);
        newb = b + off;
        @(negedge clk);
        op_valid = 1'b1; op_size = sz; op_signed = sg; op_store = st;
        op_post = po; op_indexed = ix; op_ds_form = ds;
        base_val = b; index_val = x; imm = im; src_val = s;
        @(negedge clk);
        op_valid = 1'b0; base_val = '0; index_val = '0; src_val = '0;
        check("R8 req", {63'd0, mem_req_valid}, 64'd1);
        check("R8 busy", {63'd0, busy}, 64'd1);
        if (po) check("R1 post addr", mem_addr, b);
        else    check("R2 pre addr", mem_addr, newb);
        check("R4 offset via addr/wb", base_wb_data - b, off);
        check("R7 size", {62'd0, mem_size}, {62'd0, sz});
        check("R7 store", {63'd0, mem_store}, {63'd0, st});
        if (st) check("R7 wdata", mem_wdata, s & low_mask(sz));
        check("R9 no wb before rsp", {63'd0, base_wb_valid}, 64'd0);
        mem_rsp_valid = 1'b1; mem_rdata = rd;
        #1;
        check("R9 base wb valid", {63'd0, base_wb_valid}, 64'd1);
        check("R9 res valid", {63'd0, res_valid}, {63'd0, !st});
        if (po) check("R3 post wb", base_wb_data, newb);
        else    check("R2 pre wb", base_wb_data, newb);
        if (!st) begin
            if (sg && (sz == 2'd1 || sz == 2'd2))
                check("R6 sign ext", res_data, load_exp(sz, sg, rd));
            else
                check("R5 zero ext", res_data, load_exp(sz, sg, rd));
        end
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rdata = '0;
        check("R8 busy clear", {63'd0, busy}, 64'd0);
        check("R9 no wb idle", {63'd0, base_wb_valid | res_valid}, 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 2 + 1);
        // R11 reset state
        check("R11 busy", {63'd0, busy}, 64'd0);
        check("R11 req", {63'd0, mem_req_valid}, 64'd0);
        check("R11 wb", {63'd0, base_wb_valid | res_valid}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int c = 0; c < 64; c++) begin
            for (int p = 0; p < 4; p++) begin
                run_op(c[1:0], c[2], c[3], c[4], c[5], 1'b1 ^ c[5] ^ c[5], p);
                run_op(c[1:0], c[2], c[3], c[4], c[5], 1'b0, p);
            end
        end

        // R10: conflicting operations while busy are ignored
        @(negedge clk);
        op_valid = 1'b1; op_size = 2'd3; op_signed = 1'b0; op_store = 1'b0;
        op_post = 1'b1; op_indexed = 1'b0; op_ds_form = 1'b0;
        base_val = 64'h0000_2000; imm = 16'h0010;
        @(negedge clk);
        base_val = 64'h0000_9000; imm = 16'h7000; op_post = 1'b0;
        check("R10 first req", {63'd0, mem_req_valid}, 64'd1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R10 no second req", {63'd0, mem_req_valid}, 64'd0);
            check("R10 addr kept", mem_addr, 64'h0000_2000);
        end
        op_valid = 1'b0;
        mem_rsp_valid = 1'b1; mem_rdata = 64'h55;
        #1;
        check("R10 wb unchanged", base_wb_data, 64'h0000_2010);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        @(negedge clk);
        check("R10 no late req", {63'd0, mem_req_valid}, 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule